// File: doc/BRIEF.md
# UART Interrupt and Line-Status Unit

This block is the host-facing status and interrupt side of a FIFO-based serial port. It owns a receive queue whose entries carry a three-bit error tag (parity, framing, break) next to each character. It also tracks how full the transmit queue is and whether the transmit shifter is busy. From that state it builds an eight-bit line-status word, an interrupt-enable register, and one interrupt line, and it reports which source is pending through an identification code. The serial shifters sit outside. Each of them reports to this block with a one-cycle strobe: a received character with its error tag, a load of the next transmit character into the shifter, and the end of a transmit shift.

The host reaches the block through a small register port with a 3-bit address and separate write and read strobes. Read data is combinational from the current state. A read has side effects only in the cycle its read strobe is high. The queues run in one of two modes. In FIFO mode each queue is DEPTH entries deep and has a selectable trigger level. In single-register mode each queue holds one character. Clearing all four interrupt enables gives polled operation. In polled operation the host watches the status word only.

Top module: `uart_irq_status`

## Requirements
- R1: Status bit 0 (data ready) is 1 from the cycle after a character is accepted into the receive queue until the cycle after the queue becomes empty. Reading address 0 while the queue is not empty pops the head and returns its data.
- R2: In FIFO mode with enable bit 0 set, the receive interrupt (ID 0x4) is pending while the fill is at or above the trigger level and drops once the fill falls below it. Control bits 7:6 select that level: 0→1, 1→4, 2→8, 3→14.
- R3: In single-register mode (control bit 0 = 0) the queue holds one character, and with enable bit 0 set the receive interrupt is pending whenever that character is present.
- R4: Transmit-ready (ID 0x2, enable bit 1) becomes pending one cycle after the ready condition and the enable are first both true. This includes setting the enable while the condition already holds. The ready condition is an empty holding register in single-register mode, or a transmit fill below the level picked by control bits 5:4 (same table as R2) in FIFO mode. The pending flag clears on a write to address 0, or on a read of address 2 that reports ID 0x2.
- R5: Status bit 5 is 1 when the transmit queue is empty. Bit 6 is 1 when the queue is empty and the shifter is idle. Bit 7 is 1 while at least one character with a nonzero error tag is in the receive queue.
- R6: A character that arrives while the receive queue is full is discarded and sets status bit 1 (overrun). Overrun raises the line-status interrupt at once and clears on a read of status address 5. If a new overrun happens in the same cycle as that read, the overrun bit stays set.
- R7: Status bits 4:2 show the error tag of the queue head: bit 2 parity, bit 3 framing, bit 4 break. By default a tagged character raises the line-status interrupt (ID 0x6, enable bit 2) only once it is at the head. With option bit 0 at address 3 set, acceptance of a tagged character also raises it at once, and that immediate flag clears on a status read.
- R8: The interrupt-enable register at address 1 keeps bits 3:0 (receive, transmit, line status, modem). Bits 7:4 read as 0.
- R9: With all enables at 0 the interrupt line stays low, while the status word still tracks both directions.
- R10: The identification register at address 2 reports the highest pending source in this order: line status 0x6, receive 0x4, transmit 0x2, modem 0x0 (modem input high with enable bit 3). It reports 0x1 when nothing is pending, and bits 7:6 are both 1 in FIFO mode. The interrupt line is high exactly when a source is pending.
- R11: After reset the status word reads 0x60, the identification register reads 0x01, the enables read 0, and the interrupt line is low.
- R12: Address map: 0 data (read pops receive, write pushes transmit), 1 enables, 2 identification on read and control on write (bit 0 FIFO mode), 3 option, 5 status. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| rx_push | input | 1 | Receive shifter delivered a character |
| rx_char | input | 8 | Received character |
| rx_flags | input | 3 | Error tag: bit 0 parity, bit 1 framing, bit 2 break |
| tx_load | input | 1 | Transmit shifter takes the next character |
| tx_done | input | 1 | Transmit shifter finished its character |
| modem_req | input | 1 | Modem-status interrupt request level |
| irq | output | 1 | Interrupt line |

## Verification
All state sits in registers and reg_rdata and irq are combinational from it, so every strobe or register access shows up on the ports exactly one clock later. The one exception is transmit-ready, which needs a second cycle because it latches the rising edge of the ready condition. The bench drives inputs just after a falling edge and compares reg_rdata and irq against a behavioural queue model 1 ns later. It then advances the model, so each comparison sees the state produced by the previous edge. The fixed-value spot checks are placed using the same count: one cycle after a push, pop or write, and two after a transmit-ready trigger.

// File: rtl/uart_stat_pkg.sv
// Shared types and helpers for the UART status/interrupt unit.
// Assumes queue depths of at least 4 so the trigger table is meaningful.
package uart_stat_pkg;

    // Identification codes, lowest bit set means nothing pending
    typedef enum logic [3:0] {
        ID_MODEM  = 4'h0,
        ID_NONE   = 4'h1,
        ID_TXRDY  = 4'h2,
        ID_RXDATA = 4'h4,
        ID_LINE   = 4'h6
    } irq_id_e;

    // Register addresses
    localparam logic [2:0] ADDR_DATA   = 3'd0;
    localparam logic [2:0] ADDR_ENABLE = 3'd1;
    localparam logic [2:0] ADDR_IDCTL  = 3'd2;
    localparam logic [2:0] ADDR_OPTION = 3'd3;
    localparam logic [2:0] ADDR_STATUS = 3'd5;

    // Trigger level for a two-bit selector, scaled to the queue depth
    function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_stat_fifo.sv
// Receive queue with a per-entry error tag and a running count of tagged
// entries. In single-register mode the capacity is one entry. A push into
// a full queue is refused (the caller turns that into overrun).
module uart_rx_stat_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int EW    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fifo_en,
    input  logic                          push,
    input  logic [DW-1:0]                 push_data,
    input  logic [EW-1:0]                 push_err,
    input  logic                          pop,
    output logic [DW-1:0]                 head_data,
    output logic [EW-1:0]                 head_err,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          full,
    output logic                          err_any
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int EntryW = DW + EW;

    logic [EntryW-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     err_cnt;
    logic              accept, do_pop;
    logic [EntryW-1:0] head;

    assign full    = count >= (fifo_en ? CW'(DEPTH) : CW'(1));
    assign accept  = push && !full;
    assign do_pop  = pop && (count != '0);
    assign head    = mem[rd_ptr];
    assign head_data = (count != '0) ? head[DW-1:0] : '0;
    assign head_err  = (count != '0) ? head[EntryW-1:DW] : '0;
    assign err_any   = err_cnt != '0;

    // Storage write, no reset needed since empty entries are masked
    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= {push_err, push_data};
    end

    // Pointer and fill bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({accept, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Count of tagged entries still held, drives status bit 7
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_cnt <= '0;
        end else begin
            case ({accept && (push_err != '0), do_pop && (head_err != '0)})
                2'b10:   err_cnt <= err_cnt + 1'b1;
                2'b01:   err_cnt <= err_cnt - 1'b1;
                default: err_cnt <= err_cnt;
            endcase
        end
    end

endmodule

// File: rtl/uart_tx_stat_track.sv
// Tracks transmit queue fill and shifter activity. Host writes add to the
// fill (dropped when full), a load strobe moves one character into the
// shifter, a done strobe marks the shifter idle.
module uart_tx_stat_track #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_en,
    input  logic [1:0] trig_sel,
    input  logic       wr,
    input  logic       load,
    input  logic       done,
    output logic       thr_empty,
    output logic       tx_idle,
    output logic       ready_cond
);
    import uart_stat_pkg::*;
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt;
    logic          busy;
    logic          inc, dec;
    logic [CW-1:0] trig;

    assign trig       = CW'(trig_level(trig_sel, DEPTH));
    assign inc        = wr && (cnt < (fifo_en ? CW'(DEPTH) : CW'(1)));
    assign dec        = load && (cnt != '0);
    assign thr_empty  = cnt == '0;
    assign tx_idle    = (cnt == '0) && !busy;
    assign ready_cond = fifo_en ? (cnt < trig) : (cnt == '0);

    // Fill counter and shifter busy flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else begin
            case ({inc, dec})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            if (dec)       busy <= 1'b1;
            else if (done) busy <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_irq_prio.sv
// Interrupt source arbitration. Transmit-ready is edge latched: it pends
// when its enabled condition first becomes true and is cleared by a data
// write or by an identification read that reports it.
module uart_irq_prio (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [3:0]              ien,
    input  logic                    ls_cond,
    input  logic                    rx_cond,
    input  logic                    tx_cond,
    input  logic                    modem_req,
    input  logic                    thr_wr,
    input  logic                    id_rd,
    output uart_stat_pkg::irq_id_e  id,
    output logic                    irq,
    output logic                    tx_pend
);
    import uart_stat_pkg::*;

    logic armed, armed_q, tx_clr;

    assign armed  = ien[1] && tx_cond;
    assign tx_clr = thr_wr || (id_rd && (id == ID_TXRDY));

    // Transmit-ready edge latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            tx_pend <= 1'b0;
        end else begin
            armed_q <= armed;
            tx_pend <= armed && ((!armed_q) || (tx_pend && !tx_clr));
        end
    end

    // Fixed priority selection of the reported source
    always_comb begin
        if (ien[2] && ls_cond)       id = ID_LINE;
        else if (ien[0] && rx_cond)  id = ID_RXDATA;
        else if (ien[1] && tx_pend)  id = ID_TXRDY;
        else if (ien[3] && modem_req) id = ID_MODEM;
        else                         id = ID_NONE;
    end

    assign irq = id != ID_NONE;

endmodule

// File: rtl/uart_irq_status.sv
// Top of the UART status/interrupt unit: host register port, overrun and
// immediate-error flags, status word assembly. Assumes strobes from the
// shifters are single-cycle and synchronous to clk.
module uart_irq_status #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_char,
    input  logic [2:0]    rx_flags,
    input  logic          tx_load,
    input  logic          tx_done,
    input  logic          modem_req,
    output logic          irq
);
    import uart_stat_pkg::*;
    localparam int CW = $clog2(DEPTH + 1);

    logic [3:0]    ien_q;
    logic          fifo_en_q, imm_mode_q, ovr_q, imm_flag_q;
    logic [1:0]    rx_sel_q, tx_sel_q;
    logic [DW-1:0] head_data;
    logic [2:0]    head_err;
    logic [CW-1:0] rx_cnt;
    logic          rx_full, err_any;
    logic          thr_empty, tx_idle, tx_cond, tx_pend;
    logic          ls_cond, rx_cond;
    logic          wr_data, rd_data, rd_id, rd_status;
    logic [7:0]    lsr;
    irq_id_e       id;

    assign wr_data   = reg_wr && (reg_addr == ADDR_DATA);
    assign rd_data   = reg_rd && (reg_addr == ADDR_DATA);
    assign rd_id     = reg_rd && (reg_addr == ADDR_IDCTL);
    assign rd_status = reg_rd && (reg_addr == ADDR_STATUS);

    uart_rx_stat_fifo #(.DEPTH(DEPTH), .DW(DW), .EW(3)) rx_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en_q),
        .push(rx_push), .push_data(rx_char), .push_err(rx_flags),
        .pop(rd_data), .head_data(head_data), .head_err(head_err),
        .count(rx_cnt), .full(rx_full), .err_any(err_any)
    );

    uart_tx_stat_track #(.DEPTH(DEPTH)) tx_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en_q), .trig_sel(tx_sel_q),
        .wr(wr_data), .load(tx_load), .done(tx_done),
        .thr_empty(thr_empty), .tx_idle(tx_idle), .ready_cond(tx_cond)
    );

    assign ls_cond = ovr_q || (head_err != 3'b0) || imm_flag_q;
    assign rx_cond = fifo_en_q ? (rx_cnt >= CW'(trig_level(rx_sel_q, DEPTH)))
                               : (rx_cnt != '0);

    uart_irq_prio prio_i (
        .clk(clk), .rst_n(rst_n), .ien(ien_q),
        .ls_cond(ls_cond), .rx_cond(rx_cond), .tx_cond(tx_cond),
        .modem_req(modem_req), .thr_wr(wr_data), .id_rd(rd_id),
        .id(id), .irq(irq), .tx_pend(tx_pend)
    );

    // Host-writable configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q      <= 4'b0;
            fifo_en_q  <= 1'b0;
            rx_sel_q   <= 2'b0;
            tx_sel_q   <= 2'b0;
            imm_mode_q <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADDR_ENABLE: ien_q <= reg_wdata[3:0];
                ADDR_IDCTL: begin
                    fifo_en_q <= reg_wdata[0];
                    tx_sel_q  <= reg_wdata[5:4];
                    rx_sel_q  <= reg_wdata[7:6];
                end
                ADDR_OPTION: imm_mode_q <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    // Overrun and immediate-error flags, a new event beats a status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q      <= 1'b0;
            imm_flag_q <= 1'b0;
        end else begin
            if (rx_push && rx_full) ovr_q <= 1'b1;
            else if (rd_status)     ovr_q <= 1'b0;
            if (rx_push && !rx_full && (rx_flags != 3'b0) && imm_mode_q) imm_flag_q <= 1'b1;
            else if (rd_status)                                          imm_flag_q <= 1'b0;
        end
    end

    assign lsr = {err_any, tx_idle, thr_empty, head_err, ovr_q, rx_cnt != '0};

    // Read data selection
    always_comb begin
        case (reg_addr)
            ADDR_DATA:   reg_rdata = 8'(head_data);
            ADDR_ENABLE: reg_rdata = {4'b0, ien_q};
            ADDR_IDCTL:  reg_rdata = {fifo_en_q, fifo_en_q, 2'b00, id};
            ADDR_OPTION: reg_rdata = {7'b0, imm_mode_q};
            ADDR_STATUS: reg_rdata = lsr;
            default:     reg_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/uart_irq_status_chk.sv
// Property checker for uart_irq_status, attached by bind below.
module uart_irq_status_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_push,
    input logic [2:0]    reg_addr,
    input logic [7:0]    reg_rdata,
    input logic          irq,
    input logic [3:0]    ien,
    input logic [CW-1:0] rx_cnt,
    input logic          rx_full,
    input logic          ovr,
    input logic          tx_cond,
    input logic          tx_pend
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= CW'(DEPTH)); // R6
    AST_DR_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n) (rx_push && !rx_full) |=> (rx_cnt != '0)); // R1
    AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n) (rx_push && rx_full) |=> ovr); // R6
    AST_POLLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (ien == 4'b0) |-> !irq); // R9
    AST_IEN_RSVD: assert property (@(posedge clk) disable iff (!rst_n) (reg_addr == 3'd1) |-> (reg_rdata[7:4] == 4'b0)); // R8
    AST_TX_FIRE: assert property (@(posedge clk) disable iff (!rst_n) (ien[1] && tx_cond && !$past(ien[1] && tx_cond)) |=> tx_pend); // R4
endmodule

bind uart_irq_status uart_irq_status_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .irq(irq), .ien(ien_q), .rx_cnt(rx_cnt),
    .rx_full(rx_full), .ovr(ovr_q), .tx_cond(tx_cond), .tx_pend(tx_pend)
);

// File: tb/uart_irq_status_tb_top.sv
module uart_irq_status_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 0, reg_rd = 0, rx_push = 0, tx_load = 0, tx_done = 0, modem_req = 0;
    logic [2:0] reg_addr = 3'd5, rx_flags = 0;
    logic [7:0] reg_wdata = 0, rx_char = 0, reg_rdata;
    logic       irq;

    always #4 clk = ~clk;

    uart_irq_status dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_push(rx_push), .rx_char(rx_char),
        .rx_flags(rx_flags), .tx_load(tx_load), .tx_done(tx_done), .modem_req(modem_req), .irq(irq)
    );

    int    n_chk = 0, n_err = 0;
    string tag = "R11";

    // Behavioural reference state
    logic [10:0] m_rxq[$];
    bit   m_fifo = 0, m_imm = 0, m_ovr = 0, m_immf = 0, m_busy = 0, m_armq = 0, m_tpend = 0;
    int   m_rxsel = 0, m_txsel = 0, m_txc = 0;
    logic [3:0] m_ien = 0;

    function automatic int lvl(int s);
        case (s) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
    endfunction

    task automatic chk(logic [7:0] act, logic [7:0] exp, string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Compare with the model, advance the model, move to the next falling edge
    task automatic tick();
        int cnt, errs, cap, txcap, id;
        logic [2:0] herr;
        logic [7:0] hdat, lsr, exp;
        bit ls, rxc, txc, armed, clr, acc, pop, nov, nimf, ntp, inc, dec;
        #1;
        cnt = m_rxq.size();
        herr = (cnt != 0) ? m_rxq[0][10:8] : 3'b0;
        hdat = (cnt != 0) ? m_rxq[0][7:0] : 8'h0;
        errs = 0;
        foreach (m_rxq[i]) if (m_rxq[i][10:8] != 0) errs++;
        ls  = m_ovr || (herr != 0) || m_immf;
        rxc = m_fifo ? (cnt >= lvl(m_rxsel)) : (cnt != 0);
        txc = m_fifo ? (m_txc < lvl(m_txsel)) : (m_txc == 0);
        if (m_ien[2] && ls) id = 6;
        else if (m_ien[0] && rxc) id = 4;
        else if (m_ien[1] && m_tpend) id = 2;
        else if (m_ien[3] && modem_req) id = 0;
        else id = 1;
        lsr = {errs != 0, (m_txc == 0) && !m_busy, m_txc == 0, herr, m_ovr, cnt != 0};
        case (reg_addr)
            3'd0: exp = hdat;
            3'd1: exp = {4'b0, m_ien};
            3'd2: exp = {m_fifo, m_fifo, 2'b00, 4'(id)};
            3'd3: exp = {7'b0, m_imm};
            3'd5: exp = lsr;
            default: exp = 8'h00;
        endcase
        chk(reg_rdata, exp, tag);
        chk({7'b0, irq}, {7'b0, id != 1}, tag);
        // next state
        cap   = m_fifo ? 16 : 1;
        txcap = m_fifo ? 16 : 1;
        acc   = rx_push && (cnt < cap);
        pop   = reg_rd && reg_addr == 0 && cnt != 0;
        nov   = (rx_push && cnt >= cap) ? 1 : ((reg_rd && reg_addr == 5) ? 0 : m_ovr);
        nimf  = (acc && rx_flags != 0 && m_imm) ? 1 : ((reg_rd && reg_addr == 5) ? 0 : m_immf);
        armed = m_ien[1] && txc;
        clr   = (reg_wr && reg_addr == 0) || (reg_rd && reg_addr == 2 && id == 2);
        ntp   = armed && (!m_armq || (m_tpend && !clr));
        inc   = reg_wr && reg_addr == 0 && m_txc < txcap;
        dec   = tx_load && m_txc > 0;
        if (pop) void'(m_rxq.pop_front());
        if (acc) m_rxq.push_back({rx_flags, rx_char});
        m_ovr = nov; m_immf = nimf; m_tpend = ntp; m_armq = armed;
        m_txc = m_txc + int'(inc) - int'(dec);
        if (dec) m_busy = 1; else if (tx_done) m_busy = 0;
        if (reg_wr) begin
            case (reg_addr)
                3'd1: m_ien = reg_wdata[3:0];
                3'd2: begin m_fifo = reg_wdata[0]; m_txsel = reg_wdata[5:4]; m_rxsel = reg_wdata[7:6]; end
                3'd3: m_imm = reg_wdata[0];
                default: ;
            endcase
        end
        @(posedge clk); @(negedge clk);
        reg_wr = 0; reg_rd = 0; rx_push = 0; tx_load = 0; tx_done = 0; reg_addr = 3'd5;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d; tick();
    endtask
    task automatic rd(logic [2:0] a);
        reg_rd = 1; reg_addr = a; tick();
    endtask
    task automatic push(logic [7:0] d, logic [2:0] e);
        rx_push = 1; rx_char = d; rx_flags = e; tick();
    endtask
    task automatic peek(logic [2:0] a, logic [7:0] exp, string req);
        reg_addr = a; #1; chk(reg_rdata, exp, req); tick();
    endtask
    task automatic irq_is(bit exp, string req);
        chk({7'b0, irq}, {7'b0, exp}, req);
    endtask

    initial begin
        #(8 * 100000);
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        tag = "R11";
        peek(3'd5, 8'h60, "R11"); peek(3'd2, 8'h01, "R11"); peek(3'd1, 8'h00, "R11"); irq_is(0, "R11");
        tag = "R12"; peek(3'd7, 8'h00, "R12");
        tag = "R8";
        wr(3'd1, 8'hFF); peek(3'd1, 8'h0F, "R8"); wr(3'd1, 8'h00); tick();
        tag = "R9";
        wr(3'd2, 8'h01);
        push(8'hA1, 0); peek(3'd5, 8'h61, "R1");
        push(8'hA2, 0); push(8'hA3, 0); irq_is(0, "R9");
        rd(3'd0); rd(3'd0); rd(3'd0); peek(3'd5, 8'h60, "R1");
        tag = "R2";
        wr(3'd1, 8'h01);
        for (int s = 0; s < 4; s++) begin
            wr(3'd2, 8'((s << 6) | 1));
            for (int k = 0; k < lvl(s) - 1; k++) push(8'(k), 0);
            irq_is(0, "R2");
            push(8'hEE, 0); irq_is(1, "R2");
            rd(3'd0); irq_is(0, "R2");
            for (int k = 0; k < lvl(s) - 1; k++) rd(3'd0);
        end
        tag = "R3";
        wr(3'd2, 8'h00);
        push(8'h41, 0); irq_is(1, "R3"); peek(3'd0, 8'h41, "R3");
        push(8'h42, 0); peek(3'd5, 8'h63, "R6");
        rd(3'd0); rd(3'd5); peek(3'd5, 8'h60, "R6");
        tag = "R6";
        wr(3'd2, 8'h01); wr(3'd1, 8'h04);
        for (int k = 0; k < 16; k++) push(8'(k + 16), 0);
        irq_is(0, "R6");
        push(8'hFF, 0); irq_is(1, "R6");
        rd(3'd5); irq_is(0, "R6");
        for (int k = 0; k < 16; k++) rd(3'd0);
        peek(3'd5, 8'h60, "R1");
        tag = "R7";
        push(8'h10, 3'b000); push(8'h11, 3'b001); irq_is(0, "R7");
        peek(3'd5, 8'hE1, "R5");
        rd(3'd0); irq_is(1, "R7"); peek(3'd5, 8'hE5, "R7");
        rd(3'd0); irq_is(0, "R7");
        push(8'h12, 3'b010); peek(3'd5, 8'hE9, "R7"); rd(3'd0);
        wr(3'd3, 8'h01);
        push(8'h20, 3'b000); push(8'h21, 3'b100); irq_is(1, "R7");
        rd(3'd5); irq_is(0, "R7");
        rd(3'd0); irq_is(1, "R7"); peek(3'd5, 8'hF1, "R7");
        rd(3'd0); irq_is(0, "R7");
        wr(3'd3, 8'h00);
        tag = "R4";
        wr(3'd1, 8'h00); wr(3'd2, 8'h00);
        wr(3'd1, 8'h02); irq_is(0, "R4"); tick(); irq_is(1, "R4");
        peek(3'd2, 8'h02, "R4");
        rd(3'd2); irq_is(0, "R4");
        wr(3'd0, 8'h55); tag = "R5"; peek(3'd5, 8'h00, "R5");
        tx_load = 1; tick(); peek(3'd5, 8'h20, "R5"); irq_is(1, "R4");
        tx_done = 1; tick(); peek(3'd5, 8'h60, "R5");
        tag = "R4";
        wr(3'd0, 8'h66); irq_is(0, "R4");
        tx_load = 1; tick(); tx_done = 1; tick(); rd(3'd2);
        wr(3'd2, 8'h11);
        for (int k = 0; k < 6; k++) wr(3'd0, 8'(k));
        tx_load = 1; tick(); tx_load = 1; tick(); irq_is(0, "R4");
        tx_load = 1; tick(); tick(); irq_is(1, "R4");
        for (int k = 0; k < 3; k++) begin tx_load = 1; tick(); end
        tx_done = 1; tick(); rd(3'd2);
        tag = "R10";
        wr(3'd1, 8'h00); wr(3'd2, 8'h00); modem_req = 1;
        wr(3'd1, 8'h0F); tick(); peek(3'd2, 8'h02, "R10");
        rd(3'd2); peek(3'd2, 8'h00, "R10");
        push(8'h31, 0); peek(3'd2, 8'h04, "R10");
        push(8'h32, 0); peek(3'd2, 8'h06, "R10");
        rd(3'd5); peek(3'd2, 8'h04, "R10");
        rd(3'd0); peek(3'd2, 8'h00, "R10");
        modem_req = 0; peek(3'd2, 8'h01, "R10");
        wr(3'd2, 8'h01); peek(3'd2, 8'hC1, "R10");
        wr(3'd1, 8'h00); tick();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule